// File: doc/BRIEF.md
# JTAG Debug Receive Data Register

This block is the receive-side data register of a JTAG debug port. A debugger scans a 35-bit word through it. The word holds a 32-bit payload and two control flags. When the scan is committed, the block hands the payload to a receive register on the core side. It also updates two bits of a transmit/receive control/status word that the core-resident debug handler polls. One flag marks the last word of a block download. The handler branches on that flag, so it needs no loop counter of its own. The other flag throws away receive data that has not been consumed.

The scan chain runs on the test clock. The receive register and status bits run on the core clock. A single toggle carries each committed update across a two-flop synchronizer, and the command fields are held stable in the test-clock domain while it crosses. The receive-valid flag travels back the other way through a second synchronizer, so that a capture lets the debugger poll for readiness. A test reset clears only the chain. A system reset clears only the core-side state.

Top module: `dbg_rx_dr`

## Requirements
- R1: With `dr_sel` and `shift_dr` high, each rising `tck` moves the chain one place toward `tdo` and loads `tdi` into bit 34. `tdo` always shows chain bit 0. The chain layout is: bit 0 flush flag, bit 1 download flag, bits 33:2 payload, bit 34 spare.
- R2: With `dr_sel` and `capture_dr` high, a rising `tck` loads chain bit 0 with the receive-valid flag as seen in the test-clock domain, and loads bits 34:1 with zero.
- R3: An update (`dr_sel` and `update_dr` high at a rising `tck`) with the flush flag clear and receive-valid clear writes the payload into `rx_data` and sets receive-valid within eight core clocks.
- R4: An update with the flush flag clear while receive-valid is still set is refused. `rx_data` keeps the unread word and receive-valid stays set.
- R5: Every update copies its download flag into `status[29]`, whether or not the payload is accepted.
- R6: An update with the flush flag set clears receive-valid and leaves `rx_data` unchanged.
- R7: A one-cycle `core_rd` pulse clears receive-valid.
- R8: `trst` (synchronous, active high, `tck` domain) sets all 35 chain bits to zero. `rst` leaves the chain contents unchanged.
- R9: `rst` (synchronous, active high, core domain) clears `rx_data`, receive-valid and the download flag. `trst` leaves all three unchanged.
- R10: `status[31]` is receive-valid, `status[29]` is the download flag, and every other status bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Core system reset, synchronous, active high |
| tck | input | 1 | Test clock |
| trst | input | 1 | Test reset, synchronous to tck, active high |
| dr_sel | input | 1 | This data register is the one the current instruction selects |
| capture_dr | input | 1 | TAP controller is in Capture-DR |
| shift_dr | input | 1 | TAP controller is in Shift-DR |
| update_dr | input | 1 | TAP controller is in Update-DR |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, chain bit 0 |
| core_rd | input | 1 | Core consumes the receive register |
| rx_data | output | 32 | Receive register |
| status | output | 32 | Control/status word: bit 31 receive-valid, bit 29 download flag |

## Verification
A bad receive-valid flag becomes visible in two places. It shows on `status[31]` a few core clocks after the update. It also shows in bit 0 of the next capture, and it decides whether the following word overwrites `rx_data`. A wrong valid flag therefore shows up as a lost word or a clobbered word one scan later. Faults in chain ordering or in reset handling show up in the bit order shifted out of `tdo` in the next 35 shifts. The bench therefore reads back chains that were shifted in but never committed, across each of the two resets.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;

    // Payload carried by one debugger scan
    parameter int PAYLOAD_W = 32;
    // Two flag bits below the payload and one spare bit above it
    localparam int CHAIN_W   = PAYLOAD_W + 3;
    localparam int FLUSH_POS = 0;
    localparam int DLOAD_POS = 1;
    localparam int PAY_LSB   = 2;
    localparam int SPARE_POS = CHAIN_W - 1;

    // Control/status word that the core sees
    parameter int STAT_W    = 32;
    parameter int VALID_BIT = 31;
    parameter int DLOAD_BIT = 29;

    // Fields committed at an update and handed to the core domain
    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic                 dload;
        logic                 flush;
    } upd_cmd_t;

    typedef enum logic [1:0] {
        CH_HOLD,
        CH_CAPTURE,
        CH_SHIFT
    } chain_op_e;

    function automatic upd_cmd_t split_chain(input logic [CHAIN_W-1:0] c);
        upd_cmd_t r;
        r.payload = c[PAY_LSB +: PAYLOAD_W];
        r.dload   = c[DLOAD_POS];
        r.flush   = c[FLUSH_POS];
        return r;
    endfunction

    function automatic logic [CHAIN_W-1:0] capture_word(input logic valid);
        logic [CHAIN_W-1:0] r;
        r            = '0;
        r[FLUSH_POS] = valid;
        return r;
    endfunction

    function automatic logic [STAT_W-1:0] make_status(input logic valid, input logic dload);
        logic [STAT_W-1:0] r;
        r            = '0;
        r[VALID_BIT] = valid;
        r[DLOAD_BIT] = dload;
        return r;
    endfunction

endpackage

// File: rtl/dbg_rx_sync.sv
module dbg_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) stg <= d;
        end else begin : g_many
            always_ff @(posedge clk) stg <= {stg[STAGES-2:0], d};
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dbg_rx_chain.sv
module dbg_rx_chain
    import dbg_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               tck,
    input  logic               trst,
    input  logic               dr_sel,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    input  logic               rx_valid_core,
    output logic               tdo,
    output logic [CHAIN_W-1:0] chain_q,
    output upd_cmd_t           cmd_q,
    output logic               upd_tgl
);
    logic      valid_tck;
    chain_op_e op;

    // Receive-valid brought into the test-clock domain for capture
    dbg_rx_sync #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk (tck),
        .d   (rx_valid_core),
        .q   (valid_tck)
    );

    always_comb begin
        op = CH_HOLD;
        if (dr_sel && capture_dr)    op = CH_CAPTURE;
        else if (dr_sel && shift_dr) op = CH_SHIFT;
    end

    always_ff @(posedge tck) begin
        if (trst) begin
            chain_q <= '0;
        end else begin
            case (op)
                CH_CAPTURE: chain_q <= capture_word(valid_tck);
                CH_SHIFT:   chain_q <= {tdi, chain_q[SPARE_POS:1]};
                default:    chain_q <= chain_q;
            endcase
        end
    end

    assign tdo = chain_q[0];

    // The committed command and the toggle are left out of test reset: the
    // core side follows the toggle level, so clearing it would look like a
    // fresh update.
    always_ff @(posedge tck) begin
        if (dr_sel && update_dr && !trst) begin
            cmd_q   <= split_chain(chain_q);
            upd_tgl <= ~upd_tgl;
        end
    end
endmodule

// File: rtl/dbg_rx_wr.sv
module dbg_rx_wr
    import dbg_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tgl_s,
    input  upd_cmd_t             cmd,
    input  logic                 core_rd,
    output logic [PAYLOAD_W-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 dload,
    output logic                 apply,
    output logic                 wr_en
);
    logic tgl_seen;

    // The last toggle level is tracked even during reset, so leaving
    // reset never produces a stale update.
    always_ff @(posedge clk) tgl_seen <= tgl_s;

    assign apply = !rst && (tgl_s != tgl_seen);
    assign wr_en = apply && !cmd.flush && !rx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            dload    <= 1'b0;
        end else begin
            if (apply) dload <= cmd.dload;
            if (wr_en) rx_data <= cmd.payload;
            if (apply && cmd.flush) rx_valid <= 1'b0;
            else if (wr_en)         rx_valid <= 1'b1;
            else if (core_rd)       rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_rx_dr.sv
module dbg_rx_dr
    import dbg_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tck,
    input  logic              trst,
    input  logic              dr_sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              core_rd,
    output logic [PAYLOAD_W-1:0] rx_data,
    output logic [STAT_W-1:0] status
);
    logic [CHAIN_W-1:0] chain_q;
    upd_cmd_t           cmd_q;
    logic               upd_tgl;
    logic               tgl_s;
    logic               rx_valid;
    logic               dload;
    logic               apply;
    logic               wr_en;

    dbg_rx_chain #(.SYNC_STAGES(SYNC_STAGES)) u_chain (
        .tck           (tck),
        .trst          (trst),
        .dr_sel        (dr_sel),
        .capture_dr    (capture_dr),
        .shift_dr      (shift_dr),
        .update_dr     (update_dr),
        .tdi           (tdi),
        .rx_valid_core (rx_valid),
        .tdo           (tdo),
        .chain_q       (chain_q),
        .cmd_q         (cmd_q),
        .upd_tgl       (upd_tgl)
    );

    dbg_rx_sync #(.STAGES(SYNC_STAGES)) u_tsync (
        .clk (clk),
        .d   (upd_tgl),
        .q   (tgl_s)
    );

    dbg_rx_wr u_wr (
        .clk      (clk),
        .rst      (rst),
        .tgl_s    (tgl_s),
        .cmd      (cmd_q),
        .core_rd  (core_rd),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .dload    (dload),
        .apply    (apply),
        .wr_en    (wr_en)
    );

    assign status = make_status(rx_valid, dload);
endmodule

// File: rtl/dbg_rx_dr_chk.sv
module dbg_rx_dr_chk
    import dbg_rx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 tck,
    input logic                 trst,
    input logic                 dr_sel,
    input logic                 shift_dr,
    input logic                 capture_dr,
    input logic [CHAIN_W-1:0]   chain_q,
    input logic                 apply,
    input upd_cmd_t             cmd_q,
    input logic                 core_rd,
    input logic                 rx_valid,
    input logic                 dload,
    input logic [PAYLOAD_W-1:0] rx_data
);
    // R1: shifting moves the chain one place toward tdo
    assert_shift_order_R1: assert property (@(posedge tck) disable iff (trst)
        (dr_sel && shift_dr && !capture_dr) |=> (chain_q[SPARE_POS-1:0] == $past(chain_q[SPARE_POS:1])));

    // R3: valid only rises from an accepted, non-flush update
    assert_valid_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(apply && !cmd_q.flush));

    // R4: an unread word is never overwritten
    assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (rst)
        (apply && !cmd_q.flush && rx_valid) |=> ($stable(rx_data) && rx_valid));

    // R5: each update lands its download flag
    assert_dload_copy_R5: assert property (@(posedge clk) disable iff (rst)
        apply |=> (dload == $past(cmd_q.dload)));

    // R6: flush empties the receive side without touching data
    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (apply && cmd_q.flush) |=> (!rx_valid && $stable(rx_data)));

    // R7: a core read consumes the word
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (core_rd && !apply) |=> !rx_valid);

    // R8: test reset empties the chain
    assert_trst_clears_R8: assert property (@(posedge tck)
        trst |=> (chain_q == '0));
endmodule

bind dbg_rx_dr dbg_rx_dr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tck        (tck),
    .trst       (trst),
    .dr_sel     (dr_sel),
    .shift_dr   (shift_dr),
    .capture_dr (capture_dr),
    .chain_q    (chain_q),
    .apply      (apply),
    .cmd_q      (cmd_q),
    .core_rd    (core_rd),
    .rx_valid   (rx_valid),
    .dload      (dload),
    .rx_data    (rx_data)
);

// File: tb/dbg_rx_dr_bench.sv
module dbg_rx_dr_bench;
    localparam int PW = 32;
    localparam int CW = PW + 3;

    logic clk = 1'b0;
    logic tck = 1'b0;
    logic rst = 1'b1;
    logic trst = 1'b1;
    logic dr_sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic core_rd = 1'b0;
    logic tdo;
    logic [PW-1:0] rx_data;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    always #15 tck = ~tck;

    dbg_rx_dr u_dbg_rx_dr (
        .clk(clk), .rst(rst), .tck(tck), .trst(trst), .dr_sel(dr_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .core_rd(core_rd), .rx_data(rx_data), .status(status)
    );

    typedef struct {
        logic [PW-1:0] data;
        logic          valid;
        logic          dl;
        string         tag;
    } exp_t;

    exp_t sb_q[$];

    // Reference model state
    logic [PW-1:0] m_data = '0;
    logic          m_valid = 1'b0;
    logic          m_dl = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        e.data = m_data; e.valid = m_valid; e.dl = m_dl; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: pops each expected item once the core side has settled
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            repeat (8) @(posedge clk);
            @(negedge clk);
            check({sb_q[0].tag, " rx_data"}, 64'(rx_data), 64'(sb_q[0].data));
            check({sb_q[0].tag, " valid bit31"}, 64'(status[31]), 64'(sb_q[0].valid));
            check({sb_q[0].tag, " dload bit29"}, 64'(status[29]), 64'(sb_q[0].dl));
            check("R10 other status bits", 64'(status & ~32'hA000_0000), 64'd0);
            void'(sb_q.pop_front());
        end
    end

    task automatic shift_bits(input logic [CW-1:0] din, output logic [CW-1:0] dout);
        for (int i = 0; i < CW; i++) begin
            @(negedge tck);
            dr_sel = 1'b1; shift_dr = 1'b1;
            dout[i] = tdo;
            tdi = din[i];
        end
        @(negedge tck);
        shift_dr = 1'b0; dr_sel = 1'b0;
    endtask

    task automatic scan(input logic flush, input logic dl, input logic [PW-1:0] pay,
                        input string tag);
        logic [CW-1:0] din, dout;
        din = {1'b0, pay, dl, flush};
        @(negedge tck);
        dr_sel = 1'b1; capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0;
        shift_bits(din, dout);
        // R2: capture exposes receive-valid in bit 0, zeros above
        check({"R2 capture bit0 ", tag}, 64'(dout[0]), 64'(m_valid));
        check({"R2 capture upper ", tag}, 64'(dout[CW-1:1]), 64'd0);
        dr_sel = 1'b1; update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0; dr_sel = 1'b0;
        m_dl = dl;
        if (flush) m_valid = 1'b0;
        else if (!m_valid) begin m_data = pay; m_valid = 1'b1; end
        push_exp(tag);
    endtask

    initial begin
        logic [CW-1:0] pat, got;
        repeat (4) @(negedge tck);
        rst = 1'b0; trst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 reset rx_data", 64'(rx_data), 64'd0);
        check("R10 reset status", 64'(status), 64'd0);
        check("R8 reset tdo", 64'(tdo), 64'd0);

        scan(1'b0, 1'b0, 32'hDEAD_BEEF, "R3 first write");
        scan(1'b0, 1'b1, 32'h1234_5678, "R4 refused write, R5 dload");
        @(negedge clk); core_rd = 1'b1; @(negedge clk); core_rd = 1'b0;
        m_valid = 1'b0; push_exp("R7 core read");
        scan(1'b0, 1'b0, 32'hA5A5_0F0F, "R3 second write, R5 dload low");
        scan(1'b1, 1'b1, 32'hFFFF_FFFF, "R6 flush");
        scan(1'b0, 1'b1, 32'h0000_0001, "R3 write after flush");

        // R8/R1: rst leaves an uncommitted chain intact; order LSB first
        pat = 35'h5_3C96_A17E;
        shift_bits(pat, got);
        @(negedge clk); rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
        m_data = '0; m_valid = 1'b0; m_dl = 1'b0;
        push_exp("R9 system reset");
        shift_bits('0, got);
        check("R8 R1 chain kept across rst", 64'(got), 64'(pat));

        // R9: trst leaves the core state, R8: trst clears the chain
        scan(1'b0, 1'b1, 32'hCAFE_F00D, "R3 write before trst");
        shift_bits(pat, got);
        @(negedge tck); trst = 1'b1; @(negedge tck); trst = 1'b0;
        shift_bits('0, got);
        check("R8 chain cleared by trst", 64'(got), 64'd0);
        push_exp("R9 core state kept across trst");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule